// File: doc/BRIEF.md
# Modem Control and Status Loopback

This block keeps the modem control byte of a legacy serial controller and produces the modem status byte that software reads. When the loopback control bit is set, the four control outputs are fed back onto the four status inputs inside the block. When it is clear, the status inputs take fixed values: carrier detect and data set ready are held active, and clear-to-send and ring indicator are held inactive. No external modem pin is sampled.

The low nibble of the status byte holds sticky change bits. They are set only when a control write changes a derived status level. A status read returns the current byte and clears those change bits on the same clock edge. The OR of the change bits leaves the block as a pending flag. Interrupt priority logic outside the block combines that flag with its modem-status enable.

Top module: `mdm_loop_ctl`

## Requirements
- R1: A control write stores data bits 4:0. Control bits 7:5 always read 0. Control bit 4 is loopback, bit 3 is OUT2, bit 2 is OUT1, bit 1 is RTS and bit 0 is DTR.
- R2: After reset the control byte is 0x00, the status byte is 0xA0 and the pending flag is low.
- R3: With loopback clear, the status levels in bits 7:4 read 1010b. From bit 7 down these are DCD=1, RI=0, DSR=1 and CTS=0.
- R4: With loopback set, status bit 4 (CTS) follows RTS, bit 5 (DSR) follows DTR, bit 6 (RI) follows OUT1 and bit 7 (DCD) follows OUT2.
- R5: A control write that changes the derived CTS, DSR or DCD level sets status bit 0, 1 or 3 respectively. A write that leaves a level unchanged sets no bit for that level.
- R6: Status bit 2 is set by a control write only when it takes derived RI from 1 to 0. A 0-to-1 change of RI sets nothing.
- R7: A control write replaces the level bits 7:4 and keeps every change bit that is already set.
- R8: A status read returns the byte as it stands before the read edge. From the next cycle bits 3:0 are 0, unless a write in the same cycle raises them again.
- R9: When a read and a write fall in the same cycle, the change bits that were set before are cleared and the change bits raised by that write are kept.
- R10: The pending output is high exactly when any of status bits 3:0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control byte write data |
| ctl_o | output | 8 | Current control byte |
| sts_re_i | input | 1 | Status read strobe; clears the change bits at the edge |
| sts_o | output | 8 | Current status byte: levels in 7:4, change bits in 3:0 |
| delta_pend_o | output | 1 | Any change bit set |

## Verification
The bench targets these corner cases:

- **Leaving loopback.** A write that clears loopback while DTR was low must raise the DSR change bit. A design that compared raw control bits instead of derived levels would miss that change.
- **Ring indicator direction.** The bench drives RI through both directions. A design that flagged any RI change would set bit 2 on the rising write.
- **Read and write in one cycle.** The bench issues both in the same cycle. A design that gave the clear priority would lose the newly raised change.
- **Repeated identical writes.** The bench checks that change bits stay sticky across identical writes and that the upper control bits are dropped.

Random traffic then runs under a per-cycle behavioural model.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  parameter int DW    = 8;
  parameter int CTL_W = 5;
  parameter int LVL_W = 4;

  localparam logic [DW-1:0] CTL_MASK = DW'((1 << CTL_W) - 1);

  // control bit positions
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_OUT1 = 2;
  localparam int C_OUT2 = 3;
  localparam int C_LOOP = 4;

  // level / change index inside a nibble (status bit = LVL_W + idx for levels)
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  // forced levels outside loopback
  localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'((1 << L_DCD) | (1 << L_DSR));
endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
  import mdm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctl_q_o,
  output logic [DW-1:0] ctl_nxt_o
);
  assign ctl_nxt_o = wdata_i & CTL_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q_o <= '0;
    else if (we_i) ctl_q_o <= ctl_nxt_o;
  end
endmodule

// File: rtl/mdm_lvl_map.sv
module mdm_lvl_map
  import mdm_pkg::*;
(
  input  logic [CTL_W-1:0] ctl_i,
  output logic [LVL_W-1:0] lvl_o
);
  always_comb begin
    if (ctl_i[C_LOOP]) begin
      lvl_o        = '0;
      lvl_o[L_CTS] = ctl_i[C_RTS];
      lvl_o[L_DSR] = ctl_i[C_DTR];
      lvl_o[L_RI]  = ctl_i[C_OUT1];
      lvl_o[L_DCD] = ctl_i[C_OUT2];
    end else begin
      lvl_o = LVL_IDLE;
    end
  end
endmodule

// File: rtl/mdm_delta_trk.sv
module mdm_delta_trk
  import mdm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [LVL_W-1:0] lvl_old_i,
  input  logic [LVL_W-1:0] lvl_new_i,
  output logic [LVL_W-1:0] delta_o
);
  logic [LVL_W-1:0] hit;

  for (genvar i = 0; i < LVL_W; i++) begin : g_hit
    if (i == L_RI) begin : g_fall
      assign hit[i] = we_i & lvl_old_i[i] & ~lvl_new_i[i];
    end else begin : g_chg
      assign hit[i] = we_i & (lvl_old_i[i] ^ lvl_new_i[i]);
    end
  end

  // read clears old changes; changes raised by a same-cycle write survive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) delta_o <= '0;
    else         delta_o <= (re_i ? '0 : delta_o) | hit;
  end
endmodule

// File: rtl/mdm_loop_ctl.sv
module mdm_loop_ctl
  import mdm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic [DW-1:0] ctl_wdata_i,
  output logic [DW-1:0] ctl_o,
  input  logic          sts_re_i,
  output logic [DW-1:0] sts_o,
  output logic          delta_pend_o
);
  logic [DW-1:0]    ctl_q, ctl_nxt;
  logic [LVL_W-1:0] lvl_cur, lvl_nxt, delta;

  mdm_ctl_reg u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctl_we_i),
    .wdata_i  (ctl_wdata_i),
    .ctl_q_o  (ctl_q),
    .ctl_nxt_o(ctl_nxt)
  );

  mdm_lvl_map u_map_cur (.ctl_i(ctl_q[CTL_W-1:0]),   .lvl_o(lvl_cur));
  mdm_lvl_map u_map_nxt (.ctl_i(ctl_nxt[CTL_W-1:0]), .lvl_o(lvl_nxt));

  mdm_delta_trk u_dlt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctl_we_i),
    .re_i     (sts_re_i),
    .lvl_old_i(lvl_cur),
    .lvl_new_i(lvl_nxt),
    .delta_o  (delta)
  );

  assign ctl_o        = ctl_q;
  assign sts_o        = {lvl_cur, delta};
  assign delta_pend_o = |delta;
endmodule

// File: rtl/mdm_loop_chk.sv
module mdm_loop_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctl_we_i,
  input logic       sts_re_i,
  input logic [7:0] ctl_o,
  input logic [7:0] sts_o,
  input logic       delta_pend_o
);
  assert_ctl_hi_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o[7:5] == 3'b000);

  assert_idle_levels_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_o[4] |-> sts_o[7:4] == 4'b1010);

  assert_loop_map_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o[4] |-> (sts_o[4] == ctl_o[1] && sts_o[5] == ctl_o[0] &&
                  sts_o[6] == ctl_o[2] && sts_o[7] == ctl_o[3]));

  assert_no_write_no_delta_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i |=> (sts_o[3:0] & ~$past(sts_o[3:0])) == 4'b0000);

  assert_teri_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_o[2]) |-> ($past(sts_o[6]) && !sts_o[6]));

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_re_i |=> (sts_o[3:0] & $past(sts_o[3:0])) == $past(sts_o[3:0]));

  assert_read_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_re_i && !ctl_we_i) |=> sts_o[3:0] == 4'b0000);

  assert_pend_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_re_i && !ctl_we_i) |=> !delta_pend_o);
endmodule

bind mdm_loop_ctl mdm_loop_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_we_i    (ctl_we_i),
  .sts_re_i    (sts_re_i),
  .ctl_o       (ctl_o),
  .sts_o       (sts_o),
  .delta_pend_o(delta_pend_o)
);

// File: tb/sim_mdm_loop_ctl.sv
`timescale 1ns/1ps
module sim_mdm_loop_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] ctl, sts;
  logic       pend;

  int n_chk = 0, n_fail = 0;
  int m_ctl = 0, m_sts = 'hA0;
  bit done = 0;

  always #5 clk = ~clk;

  mdm_loop_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(we), .ctl_wdata_i(wd),
    .ctl_o(ctl), .sts_re_i(re), .sts_o(sts), .delta_pend_o(pend)
  );

  function automatic int lv(int c);
    int r = 0;
    if (c & 'h10) begin
      if (c & 'h02) r |= 'h10;
      if (c & 'h01) r |= 'h20;
      if (c & 'h04) r |= 'h40;
      if (c & 'h08) r |= 'h80;
    end else r = 'hA0;
    return r;
  endfunction

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = 0; m_sts = 'hA0;
    end else begin
      int d, o, n;
      d = re ? 0 : (m_sts & 'hF);
      if (we) begin
        o = lv(m_ctl); n = lv(wd & 'h1F);
        if ((o ^ n) & 'h10) d |= 1;
        if ((o ^ n) & 'h20) d |= 2;
        if ((o ^ n) & 'h80) d |= 8;
        if ((o & 'h40) && !(n & 'h40)) d |= 4;
        m_ctl = wd & 'h1F;
      end
      m_sts = lv(m_ctl) | d;
    end
  end

  task automatic chk(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic cmp_model();
    chk(int'(ctl), m_ctl, "R1 model ctl");
    chk(int'(sts), m_sts, "R7 model sts");
    chk(int'(pend), int'((m_sts & 'hF) != 0), "R10 model pend");
  endtask

  task automatic cyc(input bit w, input bit r, input logic [7:0] v);
    we = w; re = r; wd = v;
    @(posedge clk); #1;
    we = 0; re = 0;
    cmp_model();
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #23 rst_n = 1'b1;
    @(posedge clk); #1;
    chk(ctl, 'h00, "R2 reset ctl");
    chk(sts, 'hA0, "R2 reset sts");
    chk(pend, 0, "R2 reset pend");

    cyc(1, 0, 8'hFF);
    chk(ctl, 'h1F, "R1 upper bits dropped");
    chk(sts, 'hF1, "R4 loop all high, R5 cts change, R6 no ri rise");
    chk(pend, 1, "R10 pend set");

    chk(sts, 'hF1, "R8 value before read");
    cyc(0, 1, 8'h00);
    chk(sts, 'hF0, "R8 cleared after read");
    chk(pend, 0, "R10 pend clear");

    cyc(1, 0, 8'h18);
    chk(sts, 'h87, "R6 ri fall, R5 cts dsr change");
    cyc(1, 0, 8'h18);
    chk(sts, 'h87, "R7 sticky on equal write");

    cyc(1, 1, 8'h00);
    chk(sts, 'hA2, "R9 read+write keeps new dsr change, R3 idle levels");
    cyc(0, 1, 8'h00);
    chk(sts, 'hA0, "R8 clear");
    cyc(1, 0, 8'hE0);
    chk(ctl, 'h00, "R1 bits 7:5 ignored");
    chk(sts, 'hA0, "R5 no level change no delta");

    cyc(1, 0, 8'h14);
    cyc(1, 0, 8'h10);
    chk(sts, 'h04 | 'h00 | 'h08 | 'h02, "R6 ri fall in loopback");

    for (int i = 0; i < 400; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      if (v[7:6] == 2'b00) v[4] = 1'b1;
      cyc(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 3) == 0), v);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule